// File: doc/BRIEF.md
# Rate-1/2 Punctured Parallel Turbo Encoder

This block turns a serially delivered information frame of 1784 bits into a rate-1/2 coded stream. It holds the whole frame in an internal buffer and then runs two recursive systematic convolutional encoders side by side. The first reads the frame in its natural order. The second reads it through a multiplicative interleaver. A fixed puncturing sequence keeps every systematic bit and alternates the parity bit between the two encoders, so each information step yields two coded bits.

The block accepts a frame while `in_ready` is high. A bit flagged with `in_sof` is stored as bit 0 of the frame. After the last information bit is accepted the block enters its coding phase. In this phase `in_ready` stays low and the coded stream leaves one bit per cycle with `out_valid` high. After the information steps, four tail steps drive both encoder states back to zero. The final coded bit carries `out_eof`, and the block is then ready for the next frame.

Top module: `turbo_r2_encoder`

## Requirements
- R1: A frame is 1784 bits. It is accepted one bit per cycle in which `in_valid` and `in_ready` are both high, and bit j of the frame is the j-th accepted bit. `in_ready` falls in the cycle after the 1784th bit is accepted.
- R2: While coding, `in_ready` stays low. Any activity on `in_valid`, `in_sof` or `in_bit` leaves the coded stream unchanged.
- R3: Each constituent encoder has state s1..s4, where s1 is the most recent. It computes the feedback a = u ^ s3 ^ s4 and the parity p = a ^ s1 ^ s3 ^ s4, then shifts a into s1.
- R4: At information step i, encoder A takes frame bit i and encoder B takes frame bit (13*i) mod 1784.
- R5: Step i produces two coded bits. The first is the systematic bit of encoder A. The second is the parity of encoder A when i is even and the parity of encoder B when i is odd.
- R6: Steps 1784 to 1787 are tail steps. In each, every encoder takes u = s3 ^ s4, and the systematic slot carries that input of encoder A. Both states are zero after the last tail step.
- R7: A frame yields exactly 3576 coded bits on consecutive cycles with `out_valid` high. `out_eof` is high on the last of them only.
- R8: Synchronous active-high reset clears both encoder states, the puncturing phase and any partial frame. It leaves `in_ready` high and `out_valid` low.
- R9: A bit accepted with `in_sof` high restarts the frame at bit 0 and discards earlier partial bits.
- R10: Idle cycles between accepted input bits do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is offered |
| in_sof | input | 1 | Offered bit is the first of a frame |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block is loading and accepts bits |
| out_valid | output | 1 | Coded bit is present |
| out_bit | output | 1 | Coded bit |
| out_eof | output | 1 | Last coded bit of the frame |

## Verification
The assertions assume that reset is applied once at start-up. They also assume that the output is consumed every cycle: the coded stream has no backpressure, so a contiguous 3576-bit burst is a legal expectation. The stimulus always starts with reset and offers input bits only through the valid/ready handshake. It deliberately toggles `in_valid`, `in_sof` and `in_bit` while coding, because the block must ignore that activity, not because the assertions exclude it.

// File: rtl/tenc_pkg.sv
package tenc_pkg;
    localparam int FRAME_LEN = 1784;
    localparam int ILV_MULT  = 13;
    localparam int MEM       = 4;
    localparam int TAIL      = MEM;
    localparam int IDX_W     = $clog2(FRAME_LEN + TAIL);

    // bit 0 = s1 (newest) ... bit 3 = s4 (oldest)
    typedef logic [MEM-1:0] rsc_state_t;
    localparam rsc_state_t FB_TAPS  = 4'b1100;  // s3, s4
    localparam rsc_state_t PAR_TAPS = 4'b1101;  // s1, s3, s4

    typedef enum logic {ST_LOAD, ST_CODE} mode_e;

    typedef struct packed {
        logic       sys;
        logic       par;
        rsc_state_t nxt;
    } rsc_step_t;

    function automatic rsc_step_t rsc_step(rsc_state_t s, logic u, logic term);
        rsc_step_t r;
        logic uu, fb;
        uu    = term ? ^(s & FB_TAPS) : u;
        fb    = uu ^ (^(s & FB_TAPS));
        r.sys = uu;
        r.par = fb ^ (^(s & PAR_TAPS));
        r.nxt = {s[MEM-2:0], fb};
        return r;
    endfunction
endpackage

// File: rtl/tenc_frame_store.sv
module tenc_frame_store #(
    parameter int LEN = tenc_pkg::FRAME_LEN,
    parameter int W   = tenc_pkg::IDX_W
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] wa,
    input  logic         wd,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    output logic         da,
    output logic         db
);
    logic [LEN-1:0] mem;

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // Port A also walks the tail steps, whose indices exceed the frame.
    assign da = (ra < W'(LEN)) ? mem[ra] : 1'b0;
    assign db = (rb < W'(LEN)) ? mem[rb] : 1'b0;
endmodule

// File: rtl/tenc_ilv.sv
module tenc_ilv #(
    parameter int LEN  = tenc_pkg::FRAME_LEN,
    parameter int MULT = tenc_pkg::ILV_MULT,
    parameter int W    = tenc_pkg::IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] addr
);
    // Incremental form of (MULT*i) mod LEN; needs MULT < LEN.
    logic [W:0] sum;
    assign sum = {1'b0, addr} + (W+1)'(MULT);

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (adv)
            addr <= (sum >= (W+1)'(LEN)) ? W'(sum - (W+1)'(LEN)) : W'(sum);
    end
endmodule

// File: rtl/tenc_rsc.sv
module tenc_rsc
    import tenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       adv,
    input  logic       term,
    input  logic       u,
    output logic       sys,
    output logic       par,
    output rsc_state_t st
);
    rsc_step_t r;
    assign r   = rsc_step(st, u, term);
    assign sys = r.sys;
    assign par = r.par;

    always_ff @(posedge clk) begin
        if (rst || clr)
            st <= '0;
        else if (adv)
            st <= r.nxt;
    end
endmodule

// File: rtl/turbo_r2_encoder.sv
module turbo_r2_encoder
    import tenc_pkg::*;
#(
    parameter int LEN  = FRAME_LEN,
    parameter int MULT = ILV_MULT
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_eof
);
    localparam int W = $clog2(LEN + TAIL);

    mode_e      mode;
    logic [W-1:0] wr_idx, wr_addr, step, addr_b;
    logic [1:0] ph;
    logic       take, start, adv, in_tail, last_step;
    logic       bit_a, bit_b, sys_a, par_a, sys_b, par_b;
    rsc_state_t sta_a, sta_b;

    assign in_ready  = (mode == ST_LOAD);
    assign take      = in_valid && in_ready;
    assign wr_addr   = in_sof ? '0 : wr_idx;
    assign start     = take && (wr_addr == W'(LEN - 1));
    assign adv       = (mode == ST_CODE) && ph[0];
    assign in_tail   = (step >= W'(LEN));
    assign last_step = (step == W'(LEN + TAIL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= ST_LOAD;
            wr_idx <= '0;
            step   <= '0;
            ph     <= '0;
        end else if (mode == ST_LOAD) begin
            if (start) begin
                mode   <= ST_CODE;
                wr_idx <= '0;
                step   <= '0;
                ph     <= '0;
            end else if (take) begin
                wr_idx <= wr_addr + W'(1);
            end
        end else begin
            ph <= ph + 2'd1;
            if (ph[0]) begin
                if (last_step) begin
                    mode <= ST_LOAD;
                    step <= '0;
                    ph   <= '0;
                end else begin
                    step <= step + W'(1);
                end
            end
        end
    end

    tenc_frame_store #(.LEN(LEN), .W(W)) u_store (
        .clk(clk), .we(take), .wa(wr_addr), .wd(in_bit),
        .ra(step), .rb(addr_b), .da(bit_a), .db(bit_b)
    );

    tenc_ilv #(.LEN(LEN), .MULT(MULT), .W(W)) u_ilv (
        .clk(clk), .rst(rst), .clr(start), .adv(adv), .addr(addr_b)
    );

    tenc_rsc u_enc_a (
        .clk(clk), .rst(rst), .clr(start), .adv(adv), .term(in_tail),
        .u(bit_a), .sys(sys_a), .par(par_a), .st(sta_a)
    );

    tenc_rsc u_enc_b (
        .clk(clk), .rst(rst), .clr(start), .adv(adv), .term(in_tail),
        .u(bit_b), .sys(sys_b), .par(par_b), .st(sta_b)
    );

    // Puncturing: phase 0/2 systematic, 1 parity A, 3 parity B.
    always_comb begin
        out_valid = (mode == ST_CODE);
        out_eof   = out_valid && ph[0] && last_step;
        if (!out_valid)
            out_bit = 1'b0;
        else if (!ph[0])
            out_bit = sys_a;
        else
            out_bit = ph[1] ? par_b : par_a;
    end

    logic unused_sys_b;
    assign unused_sys_b = sys_b;
endmodule

// File: rtl/tenc_checker.sv
module tenc_checker
    import tenc_pkg::*;
#(
    parameter int LEN = FRAME_LEN
) (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_eof,
    input logic [1:0] ph,
    input rsc_state_t sta_a,
    input rsc_state_t sta_b
);
    localparam int NOUT = 2 * (LEN + TAIL);
    localparam int CW   = $clog2(NOUT + 1);

    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
        if (rst || !out_valid || out_eof)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_eof_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid);

    p_burst_contiguous_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |=> out_valid);

    p_burst_length_r7: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (cnt == CW'(NOUT - 1)));

    p_ready_after_eof_r1: assert property (@(posedge clk) disable iff (rst)
        out_eof |=> (in_ready && !out_valid));

    p_tail_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_eof |=> (sta_a == '0 && sta_b == '0));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (ph == 2'd0 && sta_a == '0 && sta_b == '0 && in_ready && !out_valid));
endmodule

bind turbo_r2_encoder tenc_checker #(.LEN(LEN)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_eof(out_eof), .ph(ph), .sta_a(sta_a), .sta_b(sta_b)
);

// File: tb/turbo_r2_encoder_test.sv
module turbo_r2_encoder_test;
    localparam int LEN  = 1784;
    localparam int NOUT = 2 * (LEN + 4);

    logic clk = 1'b0;
    logic rst, in_valid, in_sof, in_bit;
    logic in_ready, out_valid, out_bit, out_eof;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  finished = 0;
    bit  frm  [LEN];
    bit  expv [NOUT];
    bit  got  [NOUT];

    always #4 clk = ~clk;   // 125 MHz

    turbo_r2_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
        .out_bit(out_bit), .out_eof(out_eof)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent model of R3..R6.
    task automatic build_expected();
        bit a1 = 0, a2 = 0, a3 = 0, a4 = 0;
        bit b1 = 0, b2 = 0, b3 = 0, b4 = 0;
        for (int i = 0; i < LEN + 4; i++) begin
            bit ua, ub, fa, fb, pa, pb;
            if (i < LEN) begin
                ua = frm[i];
                ub = frm[(13 * i) % LEN];
            end else begin
                ua = a3 ^ a4;
                ub = b3 ^ b4;
            end
            fa = ua ^ a3 ^ a4;  pa = fa ^ a1 ^ a3 ^ a4;
            fb = ub ^ b3 ^ b4;  pb = fb ^ b1 ^ b3 ^ b4;
            a4 = a3; a3 = a2; a2 = a1; a1 = fa;
            b4 = b3; b3 = b2; b2 = b1; b1 = fb;
            expv[2*i]   = ua;
            expv[2*i+1] = (i % 2 == 0) ? pa : pb;
        end
    endtask

    task automatic fill(input int kind);
        logic [15:0] lf = 16'hACE1;
        for (int j = 0; j < LEN; j++) begin
            case (kind)
                0: frm[j] = 1'b0;
                1: frm[j] = 1'b1;
                2: frm[j] = (j == 0);
                default: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    frm[j] = lf[0];
                end
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0; in_sof = 0; in_bit = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // Offers the frame; gap>0 inserts idle cycles every gap-th bit (R10).
    task automatic send_frame(input int gap);
        for (int j = 0; j < LEN; j++) begin
            if (gap > 0 && j % gap == 1) begin
                @(negedge clk);
                in_valid = 0; in_bit = ~frm[j];
            end
            @(negedge clk);
            in_valid = 1; in_sof = (j == 0); in_bit = frm[j];
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0;
    endtask

    // Collects the coded burst; noise=1 wiggles the inputs meanwhile (R2).
    task automatic collect_and_check(input string tag, input bit noise);
        int  n = 0, eofs = 0, eof_pos = -1, bad = 0, first_bad = -1, guard = 0;
        bit  ready_seen = 0;
        logic [7:0] nz = 8'h5B;
        while (n < NOUT && guard < 3 * NOUT) begin
            guard++;
            if (out_valid) begin
                got[n] = out_bit;
                if (out_eof) begin eofs++; eof_pos = n; end
                if (in_ready) ready_seen = 1;
                n++;
            end
            if (noise) begin
                nz = {nz[6:0], nz[7] ^ nz[5] ^ nz[4] ^ nz[3]};
                in_valid = nz[0]; in_sof = nz[1]; in_bit = nz[2];
            end
            @(negedge clk);
        end
        in_valid = 0; in_sof = 0;
        for (int k = 0; k < n; k++)
            if (got[k] !== expv[k]) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        check(n == NOUT, "R7", {tag, " coded length"}, n, NOUT);
        check(bad == 0, "R3/R4/R5/R6", {tag, " mismatching bits"}, bad, 0);
        if (bad != 0)
            $display("  first mismatch at bit %0d: got %0d", first_bad, got[first_bad]);
        check(eofs == 1 && eof_pos == NOUT - 1, "R7", {tag, " eof position"},
              eof_pos, NOUT - 1);
        check(!ready_seen, "R2", {tag, " in_ready low while coding"}, ready_seen, 0);
        check(in_ready && !out_valid, "R1", {tag, " ready after frame"}, in_ready, 1);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(in_ready == 1, "R8", "in_ready after reset", in_ready, 1);
        check(out_valid == 0, "R8", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_pattern(input int kind, input string tag);
        fill(kind); build_expected();
        send_frame(0);
        collect_and_check(tag, 0);
    endtask

    task automatic t_gaps_and_noise();
        fill(3); build_expected();
        send_frame(3);
        collect_and_check("gaps+noise", 1);
    endtask

    task automatic t_restart_r9();
        fill(1);
        for (int j = 0; j < 200; j++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (j == 0); in_bit = 1'b1;
        end
        fill(3); build_expected();
        send_frame(0);
        collect_and_check("R9 sof restart", 0);
    endtask

    task automatic t_reset_mid_code();
        fill(1); build_expected();
        send_frame(0);
        repeat (97) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(in_ready == 1 && out_valid == 0, "R8", "state after mid-code reset",
              out_valid, 0);
        fill(2); build_expected();
        send_frame(0);
        collect_and_check("R8 after reset", 0);
    endtask

    initial begin
        rst = 1; in_valid = 0; in_sof = 0; in_bit = 0;
        t_reset();
        t_pattern(0, "R3 zeros");
        t_pattern(2, "R4 impulse");
        t_pattern(1, "R5 ones");
        t_pattern(3, "R6 random");
        t_gaps_and_noise();
        t_restart_r9();
        t_reset_mid_code();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule